// File: doc/BRIEF.md
# Scanline Playfield Pixel Generator

This block produces the one-bit background pattern pixel for each color clock of a video scanline. Software loads three pattern registers through a small write port: a 4-bit short register and two 8-bit long registers. Together they describe the twenty coarse pixels of the left half of the line. A mode bit selects whether the right half repeats the left half or shows its mirror image.

The block keeps its own horizontal position counter. The counter runs through a 228-clock line and can be pulled back to the start by a line-sync strobe. The first 68 clocks of a line are blanking, and the 160 visible clocks hold 40 coarse pixels of 4 clocks each. The pattern registers feed the output live, with no per-line copy. A write made while a register is on screen therefore changes the rest of the line from the next clock on, and this is how software builds a different pattern for each half, or changes a pattern partway across the line.

Top module: `pf_gen`

## Requirements
- R1: While the line position is 0 to 67, `hblank` is 1 and `pf_pix` is 0. From position 68 to 227, `hblank` is 0.
- R2: Visible pixel n (0..39) occupies positions 68+4n to 71+4n. Within those four clocks `pf_pix` does not change unless a register write lands inside the span.
- R3: A write to address 0 (short register) stores only `wr_data[7:4]`. Bits 3:0 have no effect on the output.
- R4: Left half, pixels 0..19, in this order: pixels 0..3 show stored data bits 4,5,6,7 of the short register. Pixels 4..11 show bits 7 down to 0 of long register A (address 1). Pixels 12..19 show bits 0 up to 7 of long register B (address 2).
- R5: When the mode bit is 0, pixel 20+k shows the same bit as pixel k, for k = 0..19.
- R6: When the mode bit is 1, pixel 39-k shows the same bit as pixel k. The mode bit is written as `wr_data[0]` at address 3.
- R7: A write sampled at the clock edge that leaves position h affects the output from position h+1 onward. Pixels already drawn keep their old values. For example, short register F0h is written with 00h at position 75: positions 68..75 show 1 and positions 76..83 show 0.
- R8: The position counter advances by one per clock and wraps from 227 to 0.
- R9: A `line_sync` sampled at an edge sets the position to 0 after that edge.
- R10: Reset clears the three pattern registers, the mode bit and the position counter, so `pf_pix` is 0 across the whole line that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync | input | 1 | Restart the line position at 0 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 short, 1 long A, 2 long B, 3 mode |
| wr_data | input | 8 | Write data |
| pf_pix | output | 1 | Playfield pixel for the current position |
| hblank | output | 1 | High during horizontal blanking |

## Verification
The pixel path is tried with several kinds of data:
- Walking single bits in each register, which show whether each coarse pixel maps to the right register bit.
- Asymmetric byte patterns such as A5h and 3Ch, which tell the mirrored right half apart from the repeated one.
- A short-register byte with only its low nibble set, which must leave the output dark.

Writes land in the middle of a displayed register, including the short register at visible clock 7. These show whether the change appears at the next clock, and that pixels already drawn keep their old values. A line-sync strobe in mid-line and free-running wraps check the position counter that all of the pixel timing depends on.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int HBLANK_CLKS = 68;
    localparam int PIX_CLKS    = 4;
    localparam int HALF_PIX    = 20;
    localparam int NUM_PIX     = 2 * HALF_PIX;
    localparam int SHORT_BITS  = 4;
    localparam int LONG_BITS   = 8;
    localparam int LINE_CLKS   = HBLANK_CLKS + NUM_PIX * PIX_CLKS;
    localparam int HPOS_W      = $clog2(LINE_CLKS);
    localparam int PIXIDX_W    = $clog2(NUM_PIX);
    localparam int SUB_W       = $clog2(PIX_CLKS);
    localparam int LONGA_END   = SHORT_BITS + LONG_BITS;

    typedef enum logic [1:0] {
        SEL_SHORT = 2'd0,
        SEL_LONGA = 2'd1,
        SEL_LONGB = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SHORT_BITS-1:0] shrt;
        logic [LONG_BITS-1:0]  longa;
        logic [LONG_BITS-1:0]  longb;
        logic                  mirror;
    } pat_t;

    // Bit shown at left-half slot q (0..HALF_PIX-1)
    function automatic logic slot_bit(pat_t r, logic [PIXIDX_W-1:0] q);
        logic [PIXIDX_W-1:0] k;
        logic b;
        if (q < PIXIDX_W'(SHORT_BITS)) begin
            k = q;
            b = r.shrt[k[1:0]];
        end else if (q < PIXIDX_W'(LONGA_END)) begin
            k = PIXIDX_W'(LONGA_END - 1) - q;
            b = r.longa[k[2:0]];
        end else begin
            k = q - PIXIDX_W'(LONGA_END);
            b = r.longb[k[2:0]];
        end
        return b;
    endfunction
endpackage

// File: rtl/pf_hcount.sv
module pf_hcount
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_sync,
    output logic [HPOS_W-1:0] hpos
);
    localparam logic [HPOS_W-1:0] LAST = HPOS_W'(LINE_CLKS - 1);

    always_ff @(posedge clk) begin
        if (rst || line_sync) hpos <= '0;
        else if (hpos == LAST) hpos <= '0;
        else hpos <= hpos + 1'b1;
    end

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (hpos == LAST) |=> (hpos == '0));
    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!line_sync && hpos != LAST) |=> (hpos == $past(hpos) + 1'b1));
    p_sync_r9: assert property (@(posedge clk) disable iff (rst)
        line_sync |=> (hpos == '0));
endmodule

// File: rtl/pf_regs.sv
module pf_regs
    import pf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             wr_sel,
    input  logic [LONG_BITS-1:0] wr_data,
    output pat_t                 pat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pat <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_SHORT: pat.shrt   <= wr_data[LONG_BITS-1 -: SHORT_BITS];
                SEL_LONGA: pat.longa  <= wr_data;
                SEL_LONGB: pat.longb  <= wr_data;
                SEL_MODE:  pat.mirror <= wr_data[0];
                default: ;
            endcase
        end
    end

    p_short_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_SHORT) |=> (pat.shrt == $past(wr_data[7:4])));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pat));
endmodule

// File: rtl/pf_sel.sv
module pf_sel
    import pf_pkg::*;
(
    input  logic [HPOS_W-1:0] hpos,
    input  pat_t              pat,
    output logic              pix,
    output logic              blank
);
    logic [HPOS_W-1:0]   off;
    logic [PIXIDX_W-1:0] pidx;
    logic [PIXIDX_W-1:0] slot;

    always_comb begin
        blank = (hpos < HPOS_W'(HBLANK_CLKS));
        off   = hpos - HPOS_W'(HBLANK_CLKS);
        pidx  = off[SUB_W +: PIXIDX_W];
        if (pidx < PIXIDX_W'(HALF_PIX))
            slot = pidx;
        else if (pat.mirror)
            slot = PIXIDX_W'(NUM_PIX - 1) - pidx;
        else
            slot = pidx - PIXIDX_W'(HALF_PIX);
        pix = blank ? 1'b0 : slot_bit(pat, slot);
    end
endmodule

// File: rtl/pf_gen.sv
module pf_gen
    import pf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_sync,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       pf_pix,
    output logic       hblank
);
    logic [HPOS_W-1:0] hpos;
    pat_t              pat;

    pf_hcount u_cnt (
        .clk(clk), .rst(rst), .line_sync(line_sync), .hpos(hpos)
    );

    pf_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(reg_sel_e'(wr_addr)),
        .wr_data(wr_data), .pat(pat)
    );

    pf_sel u_sel (
        .hpos(hpos), .pat(pat), .pix(pf_pix), .blank(hblank)
    );

    p_blank_dark_r1: assert property (@(posedge clk) disable iff (rst)
        hblank |-> !pf_pix);
    p_blank_end_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(hblank) |-> (hpos == HPOS_W'(HBLANK_CLKS)));
    p_pix_span_r2: assert property (@(posedge clk) disable iff (rst)
        (!hblank && hpos[SUB_W-1:0] != '0 && !$past(wr_en) && !$past(line_sync))
        |-> $stable(pf_pix));
    p_reset_clear_r10: assert property (@(posedge clk)
        $past(rst) |-> (pat == '0 && hpos == '0));
endmodule

// File: tb/sim_pf_gen.sv
module sim_pf_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_sync = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic pf_pix, hblank;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit chk_on = 1'b0;
    bit r10_win = 1'b0;
    int m_h = 0, m_s = 0, m_a = 0, m_b = 0, m_ref = 0;

    always #2.5 clk = ~clk;

    pf_gen u0 (
        .clk(clk), .rst(rst), .line_sync(line_sync), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pf_pix(pf_pix), .hblank(hblank)
    );

    // behavioural reference model, advanced on each edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_h = 0; m_s = 0; m_a = 0; m_b = 0; m_ref = 0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_s = wr_data / 16;
                    2'd1: m_a = wr_data;
                    2'd2: m_b = wr_data;
                    default: m_ref = wr_data % 2;
                endcase
            end
            if (line_sync || m_h == 227) m_h = 0;
            else m_h = m_h + 1;
        end
    end

    function automatic int left_bit(int k);
        if (k < 4)  return (m_s >> k) & 1;
        if (k < 12) return (m_a >> (11 - k)) & 1;
        return (m_b >> (k - 12)) & 1;
    endfunction

    function automatic int exp_pix(int h);
        int n;
        if (h < 68) return 0;
        n = (h - 68) / 4;
        if (n < 20) return left_bit(n);
        if (m_ref != 0) return left_bit(39 - n);
        return left_bit(n - 20);
    endfunction

    function automatic string tag_of(int h);
        int n;
        if (r10_win) return "R10";
        if (h < 68) return "R1";
        if (h == 0) return "R8";
        n = (h - 68) / 4;
        if ((h % 4) != 0) return "R2";
        if (n < 20) return "R4";
        return (m_ref != 0) ? "R6" : "R5";
    endfunction

    task automatic check(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s h=%0d actual=%0d expected=%0d", tag, m_h, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && chk_on) begin
            check(tag_of(m_h), int'(pf_pix), exp_pix(m_h));
            check((m_h < 68) ? "R1" : "R8", int'(hblank), (m_h < 68) ? 1 : 0);
        end
    end

    task automatic at_h(int n);
        @(negedge clk);
        while (m_h != n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(int s, int a, int b, int rf);
        at_h(10);
        wr(0, s); wr(1, a); wr(2, b); wr(3, rf);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        r10_win = 1'b1;
        chk_on = 1'b1;
        check("R10", int'(hblank), 1);
        at_h(227);
        r10_win = 1'b0;

        // walking bits, repeat then reflect
        for (int i = 0; i < 8; i++) begin
            load(1 << (i + 4 - 8 * (i / 4)), 1 << i, 1 << (7 - i), i % 2);
            at_h(227);
        end
        // asymmetric patterns in both modes
        load(8'hA0, 8'hA5, 8'h3C, 0); at_h(227);
        load(8'h50, 8'h3C, 8'hC1, 1); at_h(227);
        load(8'hF0, 8'hFF, 8'h00, 1); at_h(227);

        // R3: low nibble of the short register ignored
        load(8'h0F, 8'h00, 8'h00, 0);
        at_h(68);
        for (int i = 0; i < 16; i++) begin
            check("R3", int'(pf_pix), 0);
            @(negedge clk);
        end
        load(8'h1F, 8'h00, 8'h00, 0);
        at_h(68); check("R3", int'(pf_pix), 1);
        at_h(72); check("R3", int'(pf_pix), 0);

        // R7: mid-pixel write to the short register at visible clock 7
        load(8'hF0, 8'h00, 8'h00, 0);
        at_h(68);
        for (int i = 0; i < 7; i++) begin
            check("R7", int'(pf_pix), 1);
            @(negedge clk);
        end
        check("R7", int'(pf_pix), 1);
        wr(0, 8'h00);
        for (int i = 0; i < 8; i++) begin
            check("R7", int'(pf_pix), 0);
            @(negedge clk);
        end
        // R7: live change of long register A in the reflected half
        load(8'h00, 8'hFF, 8'h00, 1);
        at_h(200);
        wr(1, 8'h00);
        check("R7", int'(pf_pix), 0);
        at_h(227);

        // R9: line sync mid-line
        load(8'hF0, 8'h0F, 8'hAA, 0);
        at_h(150);
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        check("R9", int'(hblank), 1);
        check("R9", m_h, 0);
        at_h(227); at_h(227);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule